// File: doc/BRIEF.md
# Signed Arithmetic Unit with Condition Flags

This block performs one arithmetic or transfer operation per clock on two W-bit signed two's-complement operands and holds the outcome in a registered result. Next to the result it keeps a four-bit condition register: negative (N), zero (Z), overflow (V) and carry (C). The block supports add, subtract, increment and decrement. It also has a pass-through (move or test) of operand A and a clear. Each operation can be issued either with or without a request to update the flags.

Arithmetic uses one adder for every operation. Subtraction feeds the bitwise inverse of the second operand into the adder and forces the carry-in high. Overflow follows the sign rule on the adder's own operands and result, so it does not depend on the carry. Transfer operations touch only N and Z. A branch-condition output reports "strictly greater than zero" from the registered flags. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `tc_alu`

## Requirements
- R1: With op_sel = 0 (add), result becomes (A + B) mod 2^W on the clock edge after the request, and the carry out of the top bit is discarded from the result.
- R2: With op_sel = 1 (subtract), result becomes A + ~B + 1 mod 2^W, which equals A − B.
- R3: With op_sel = 2 (increment), result becomes A + 1. With op_sel = 3 (decrement), result becomes A + ~1 + 1, which equals A − 1. Operand B is ignored for both.
- R4: For a flag-setting arithmetic operation, V is set only when both adder inputs (A and the possibly inverted second operand) share a sign and the result sign differs from it. Adder inputs of different signs always clear V.
- R5: For a flag-setting arithmetic operation, C takes the raw carry out of the adder's top bit, including for subtract and decrement (no borrow inversion).
- R6: For every flag-setting operation, N equals the result's top bit and Z is 1 exactly when the result is all zeros.
- R7: When set_flags is 0, a valid operation updates the result only, and all four flags keep their previous values.
- R8: With op_sel = 4 (pass), result becomes A. With op_sel = 5 (clear), result becomes 0. When set_flags is 1, these two update N and Z only, and V and C keep their values.
- R9: cond_gt is 1 exactly when the registered N and Z are both 0.
- R10: When op_valid is 0, or op_sel is 6 or 7 (reserved), neither the result nor the flags change.
- R11: While reset is asserted, the result and all four flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| op_valid | input | 1 | Accept the operation on this edge |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 inc, 3 dec, 4 pass, 5 clear, 6/7 reserved) |
| set_flags | input | 1 | Update the condition flags with this operation |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand (add and subtract only) |
| result | output | W | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry out of the top bit |
| cond_gt | output | 1 | Greater-than-zero branch condition |

## Verification
The operand patterns test each flag rule on its own. Positive+positive and negative+negative pairs that cross the sign boundary show that overflow comes from the sign rule. Mixed-sign pairs that still produce a carry show that carry is separate from overflow. Subtract and decrement at zero and at the most negative value show that the carry is reported raw, with no borrow inversion. Runs of add, then pass or clear, then a non-setting operation show which flags each kind of operation may touch. The reserved codes and a dropped op_valid show that nothing changes when no valid operation is issued.

// File: rtl/tc_alu_pkg.sv
package tc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_PASS = 3'd4,
    OP_CLR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
  endfunction

  function automatic logic op_is_xfer(input alu_op_e op);
    return (op == OP_PASS) || (op == OP_CLR);
  endfunction

endpackage

// File: rtl/tc_alu_reset_sync.sv
module tc_alu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tc_alu_adder.sv
module tc_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         negate_b,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide_sum;

  always_comb begin
    b_eff     = negate_b ? ~in_b : in_b;
    wide_sum  = {1'b0, in_a} + {1'b0, b_eff} + {{W{1'b0}}, negate_b};
    sum       = wide_sum[MSB:0];
    carry_out = wide_sum[W];
    ovf       = (in_a[MSB] == b_eff[MSB]) && (wide_sum[MSB] != in_a[MSB]);
  end

endmodule

// File: rtl/tc_alu_flag_next.sv
module tc_alu_flag_next
  import tc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic         issue,
  input  logic         set_flags,
  input  logic [W-1:0] value,
  input  logic         add_carry,
  input  logic         add_ovf,
  input  alu_flags_t   flags_q,
  output alu_flags_t   flags_d,
  output logic         flags_en
);

  always_comb begin
    flags_d  = flags_q;
    flags_en = 1'b0;
    if (issue && set_flags) begin
      if (op_is_arith(op)) begin
        flags_en  = 1'b1;
        flags_d.n = value[W-1];
        flags_d.z = (value == '0);
        flags_d.v = add_ovf;
        flags_d.c = add_carry;
      end else if (op_is_xfer(op)) begin
        flags_en  = 1'b1;
        flags_d.n = value[W-1];
        flags_d.z = (value == '0);
      end
    end
  end

endmodule

// File: rtl/tc_alu.sv
module tc_alu
  import tc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_sel,
  input  logic         set_flags,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         cond_gt
);

  localparam logic [W-1:0] ONE = W'(1);

  logic         rst_n_sync;
  alu_op_e      op;
  logic         unit_step;
  logic         negate;
  logic [W-1:0] add_b;
  logic [W-1:0] add_sum;
  logic         add_carry;
  logic         add_ovf;
  logic         issue;
  logic [W-1:0] res_d;
  logic [W-1:0] res_q;
  logic         res_en;
  alu_flags_t   flags_d;
  alu_flags_t   flags_q;
  logic         flags_en;

  tc_alu_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    op        = alu_op_e'(op_sel);
    unit_step = (op == OP_INC) || (op == OP_DEC);
    negate    = (op == OP_SUB) || (op == OP_DEC);
    add_b     = unit_step ? ONE : opnd_b;
  end

  tc_alu_adder #(.W(W)) u_add (
    .in_a      (opnd_a),
    .in_b      (add_b),
    .negate_b  (negate),
    .sum       (add_sum),
    .carry_out (add_carry),
    .ovf       (add_ovf)
  );

  always_comb begin
    issue  = op_valid && (op_is_arith(op) || op_is_xfer(op));
    res_en = issue;
    res_d  = res_q;
    if (op_is_arith(op)) begin
      res_d = add_sum;
    end else if (op == OP_PASS) begin
      res_d = opnd_a;
    end else if (op == OP_CLR) begin
      res_d = '0;
    end
  end

  tc_alu_flag_next #(.W(W)) u_flg (
    .op        (op),
    .issue     (issue),
    .set_flags (set_flags),
    .value     (res_d),
    .add_carry (add_carry),
    .add_ovf   (add_ovf),
    .flags_q   (flags_q),
    .flags_d   (flags_d),
    .flags_en  (flags_en)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign result  = res_q;
  assign flag_n  = flags_q.n;
  assign flag_z  = flags_q.z;
  assign flag_v  = flags_q.v;
  assign flag_c  = flags_q.c;
  assign cond_gt = !flags_q.n && !flags_q.z;

endmodule

// File: rtl/tc_alu_chk.sv
module tc_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_sel,
  input logic         set_flags,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_c,
  input logic         cond_gt
);

  logic known_op;
  logic xfer_op;
  assign known_op = (op_sel <= 3'd5);
  assign xfer_op  = (op_sel == 3'd4) || (op_sel == 3'd5);

  // R7
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(op_valid && set_flags)) |=> $stable({flag_n, flag_z, flag_v, flag_c}));

  // R8
  p_xfer_keeps_vc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags && xfer_op) |=> $stable({flag_v, flag_c}));

  // R6
  p_nz_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags && known_op) |=> ((flag_z == (result == '0)) && (flag_n == result[W-1])));

  // R4
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags && (op_sel == 3'd0) && (opnd_a[W-1] != opnd_b[W-1])) |=> !flag_v);

  // R10
  p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !known_op) |=> ($stable(result) && $stable({flag_n, flag_z, flag_v, flag_c})));

  // R8
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 3'd5)) |=> (result == '0));

  // R9
  p_gt_consistent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cond_gt |-> (!flag_n && !flag_z));

endmodule

bind tc_alu tc_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .set_flags (set_flags),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .result    (result),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c),
  .cond_gt   (cond_gt)
);

// File: tb/tc_alu_tb_top.sv
module tc_alu_tb_top;

  localparam int W = 32;
  localparam int NV = 18;

  typedef struct packed {
    logic [3:0]   req;
    logic [2:0]   op;
    logic         sf;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic [3:0]   nzvc;
  } vec_t;

  // Flags columns are {N,Z,V,C}; expected flags carry over from the previous row.
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'd0, 1'b1, 32'h00000007, 32'h00000004, 32'h0000000B, 4'b0000}, // R1 plain add
    '{4'd4,  3'd0, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1010}, // R4 pos+pos overflow
    '{4'd7,  3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b1010}, // R7 no flag update
    '{4'd5,  3'd0, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0101}, // R5 carry, R6 zero
    '{4'd2,  3'd1, 1'b1, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0101}, // R2 equal sub, raw carry
    '{4'd2,  3'd1, 1'b1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b1000}, // R2 negative result
    '{4'd5,  3'd1, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011}, // R5 R4 sub overflow
    '{4'd8,  3'd4, 1'b1, 32'h00000000, 32'h12345678, 32'h00000000, 4'b0111}, // R8 pass keeps V,C
    '{4'd3,  3'd2, 1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, 32'h00000000, 4'b0101}, // R3 inc wraps
    '{4'd3,  3'd3, 1'b1, 32'h00000000, 32'hDEADBEEF, 32'hFFFFFFFF, 4'b1000}, // R3 dec from zero
    '{4'd3,  3'd3, 1'b1, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 4'b0011}, // R3 dec overflow
    '{4'd3,  3'd2, 1'b1, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 4'b1010}, // R3 inc overflow
    '{4'd8,  3'd4, 1'b1, 32'h00000005, 32'h00000000, 32'h00000005, 4'b0010}, // R8 pass positive
    '{4'd8,  3'd5, 1'b1, 32'h00001234, 32'h00005678, 32'h00000000, 4'b0110}, // R8 clear
    '{4'd7,  3'd4, 1'b0, 32'h80000000, 32'h00000000, 32'h80000000, 4'b0110}, // R7 move w/o flags
    '{4'd10, 3'd6, 1'b1, 32'h00001234, 32'h00000001, 32'h80000000, 4'b0110}, // R10 reserved code
    '{4'd4,  3'd0, 1'b1, 32'hC0000000, 32'hA0000000, 32'h60000000, 4'b0011}, // R4 neg+neg overflow
    '{4'd4,  3'd0, 1'b1, 32'hFFFFFFFD, 32'h00000007, 32'h00000004, 4'b0001}  // R4 mixed signs no V
  };

  logic         clk;
  logic         rst_n;
  logic         op_valid;
  logic [2:0]   op_sel;
  logic         set_flags;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_v, flag_c, cond_gt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tc_alu #(.W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .set_flags (set_flags),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .cond_gt   (cond_gt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_res(input int rq, input logic [W-1:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL R%0d result: actual %h expected %h", rq, result, exp);
    end
  endtask

  task automatic check_flags(input int rq, input logic [3:0] exp);
    checks++;
    if ({flag_n, flag_z, flag_v, flag_c} !== exp) begin
      fails++;
      $display("FAIL R%0d flags NZVC: actual %b expected %b", rq, {flag_n, flag_z, flag_v, flag_c}, exp);
    end
    // R9: greater-than-zero follows N and Z
    checks++;
    if (cond_gt !== (!exp[3] && !exp[2])) begin
      fails++;
      $display("FAIL R9 cond_gt: actual %b expected %b", cond_gt, (!exp[3] && !exp[2]));
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic sf,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_valid  = v;
    op_sel    = op;
    set_flags = sf;
    opnd_a    = a;
    opnd_b    = b;
    @(negedge clk);
    op_valid  = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; set_flags = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check_res(11, '0);
    check_flags(11, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i].op, VEC[i].sf, VEC[i].a, VEC[i].b);
      check_res(int'(VEC[i].req), VEC[i].res);
      check_flags(int'(VEC[i].req), VEC[i].nzvc);
    end

    // R10: op_valid low leaves result 4 and flags 0001 untouched
    issue(1'b0, 3'd5, 1'b1, 32'h0, 32'h0);
    check_res(10, 32'h00000004);
    check_flags(10, 4'b0001);
    // R10: reserved code 7
    issue(1'b1, 3'd7, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check_res(10, 32'h00000004);
    check_flags(10, 4'b0001);
    // R1: add with both large operands, no flags
    issue(1'b1, 3'd0, 1'b0, 32'h80000000, 32'h80000000);
    check_res(1, 32'h00000000);
    check_flags(7, 4'b0001);
    // R11: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    issue(1'b1, 3'd4, 1'b1, 32'hFFFFFFFF, 32'h0);
    check_res(11, '0);
    check_flags(11, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: pass of a negative value after reset
    issue(1'b1, 3'd4, 1'b1, 32'hFFFFFFF0, 32'h0);
    check_res(8, 32'hFFFFFFF0);
    check_flags(8, 4'b1000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule